// File: doc/BRIEF.md
# Packet Page Allocator

This block manages the packet buffer of an Ethernet controller. Software writes one-byte commands that allocate buffer space, put a packet on the transmit queue, free a packet, release the oldest received packet, or clear the whole allocator. Space is given out in 256-byte pages from a fixed pool. Each successful allocation is given a packet number, and every later command refers to the packet by that number.

Three queues hold packet numbers. The transmit queue feeds the MAC through `txReqValid`/`txReqPkt`. When the MAC reports a finished frame with `txDone`, the head packet moves to a completion queue and raises the transmit interrupt bit. The receive queue is filled through a plain test port (`rxInjWr`/`rxInjPkt`), which stands in for the receive datapath. The MAC datapath and the buffer RAM itself are outside this block.

A command byte carries the opcode in bits 7:5 and the page-count field in bits 4:0. The opcodes are 1 for allocate, 2 for clear-all, 3 for enqueue, 4 for free and 5 for release. The other opcode values do nothing.

Top module: `pkt_page_mmu`

## Requirements
- R1: While reset is held, and after it is released, `allocResult` is 8'h80, `intStatus` is 0, `portStatus` is 16'h8080 and `txReqValid` is 0.
- R2: An allocate command with a count field of n (0 to 7) asks for n+1 pages. Its result appears in `allocResult` after the second rising edge, counting the edge that samples the command. On success, bit 7 is 0 and bits 6:0 hold the packet number.
- R3: A successful allocation takes the lowest-numbered run of free contiguous pages and the lowest free packet number.
- R4: An allocation fails when the count field is above 7, when no run of free pages is long enough, or when no packet number is free. On failure `allocResult` becomes exactly 8'h80 and bit 0 of `intStatus` does not rise.
- R5: A successful allocation sets `intStatus[0]`. Writing 1 to `intAck[0]` clears it. When a set and a clear fall in the same cycle, the set wins.
- R6: A command written in the cycle after an accepted allocate command is ignored.
- R7: The clear-all command (opcode 2) frees every page and every packet number. It also empties all three queues and returns every output to its R1 value.
- R8: Enqueue (opcode 3) appends `selPkt` to the transmit queue, whose head is shown on `txReqValid`/`txReqPkt`. A `txDone` pulse while the queue is non-empty moves the head to the completion queue and sets `intStatus[1]`, which `intAck[1]` clears. A `txDone` pulse on an empty queue has no effect.
- R9: `portStatus[7]` flags an empty completion queue. `portStatus[6:0]` shows its head packet number, or 0 when it is empty. `txDonePop` drops the head.
- R10: Free (opcode 4) returns the pages and the packet number of `selPkt` to the pool. Freeing a number that is not allocated changes nothing.
- R11: `portStatus[15]` flags an empty receive queue, and `portStatus[14:8]` shows its head packet number, or 0 when it is empty. Release (opcode 5) pops the head and frees that packet's pages and number. A release on an empty queue changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command write strobe |
| cmdData | input | 8 | Opcode in [7:5], page-count field in [4:0] |
| selPkt | input | 7 | Selected packet number for enqueue and free |
| intAck | input | 2 | Write-1-to-clear for the interrupt bits |
| txDone | input | 1 | MAC finished sending the head of the transmit queue |
| txDonePop | input | 1 | Drop the head of the completion queue |
| rxInjWr | input | 1 | Push a received packet number |
| rxInjPkt | input | 7 | Received packet number |
| allocResult | output | 8 | [7] fail flag, [6:0] assigned packet number |
| intStatus | output | 2 | [0] allocation done, [1] transmit done |
| portStatus | output | 16 | [15] receive empty, [14:8] receive head, [7] completion empty, [6:0] completion head |
| txReqValid | output | 1 | Transmit queue is non-empty |
| txReqPkt | output | 7 | Head of the transmit queue |

## Verification
The checker relies on three properties of the inputs. `cmdWr` is the only way a command reaches the block. `txDone` only counts when `txReqValid` is high. An accepted allocate command is followed by one cycle in which the controller holds off. The bench keeps within these by driving every input on the falling edge, one command at a time. It never injects a receive packet number of 8 or more, and it starts the few back-to-back command tests only from a known idle state. All expected results come from a page bitmap and a packet table kept in the bench and updated by the rules above.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int CNT_W = 5;
  localparam int PKT_FIELD_W = 7;
  localparam int MAX_COUNT = 7;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_CLEAR   = 3'd2,
    OP_ENQ     = 3'd3,
    OP_FREE    = 3'd4,
    OP_RELEASE = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } mmuOp_t;

  typedef struct packed {
    logic                   doAlloc;
    logic                   doClear;
    logic                   doEnq;
    logic                   doFree;
    logic                   doRel;
    logic [CNT_W-1:0]       count;
    logic [PKT_FIELD_W-1:0] pkt;
  } mmuStrobe_t;
endpackage

// File: rtl/mmu_fifo.sv
module mmu_fifo #(
  parameter int W = 3,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wrPtr, rdPtr;

  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign head  = empty ? '0 : mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) begin
        mem[wrPtr[AW-1:0]] <= pushData;
        wrPtr <= wrPtr + 1'b1;
      end
      if (pop && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
  import mmu_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdWr,
  input  logic [7:0]             cmdData,
  input  logic [PKT_FIELD_W-1:0] selPkt,
  input  logic [1:0]             intAck,
  input  logic                   allocOk,
  input  logic                   txDoneAcc,
  output mmuStrobe_t             strobe,
  output logic [1:0]             intStatus
);
  logic             pend;
  logic [CNT_W-1:0] pendCnt;
  logic             accept;
  mmuOp_t           op;

  assign op     = mmuOp_t'(cmdData[7:5]);
  assign accept = cmdWr && !pend;

  always_comb begin
    strobe         = '0;
    strobe.doAlloc = pend;
    strobe.count   = pendCnt;
    strobe.pkt     = selPkt;
    if (accept) begin
      case (op)
        OP_CLEAR:   strobe.doClear = 1'b1;
        OP_ENQ:     strobe.doEnq   = 1'b1;
        OP_FREE:    strobe.doFree  = 1'b1;
        OP_RELEASE: strobe.doRel   = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend      <= 1'b0;
      pendCnt   <= '0;
      intStatus <= '0;
    end else begin
      pend <= accept && (op == OP_ALLOC);
      if (accept && (op == OP_ALLOC)) pendCnt <= cmdData[CNT_W-1:0];
      if (strobe.doClear) begin
        intStatus <= '0;
      end else begin
        intStatus[0] <= (intStatus[0] && !intAck[0]) || (pend && allocOk);
        intStatus[1] <= (intStatus[1] && !intAck[1]) || txDoneAcc;
      end
    end
  end
endmodule

// File: rtl/mmu_dpath.sv
module mmu_dpath
  import mmu_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int NUM_PKTS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mmuStrobe_t             strobe,
  input  logic                   txDone,
  input  logic                   txDonePop,
  input  logic                   rxInjWr,
  input  logic [PKT_FIELD_W-1:0] rxInjPkt,
  output logic                   allocOk,
  output logic                   txDoneAcc,
  output logic [7:0]             allocResult,
  output logic [15:0]            portStatus,
  output logic                   txReqValid,
  output logic [PKT_FIELD_W-1:0] txReqPkt
);
  localparam int PKT_W = $clog2(NUM_PKTS);
  localparam int PG_W  = $clog2(NUM_PAGES);
  localparam int LEN_W = 4;

  logic [NUM_PAGES-1:0] pageUsed;
  logic [NUM_PKTS-1:0]  pktUsed;
  logic [PG_W-1:0]      pktBase [NUM_PKTS];
  logic [LEN_W-1:0]     pktLen  [NUM_PKTS];

  logic [LEN_W-1:0] reqLen;
  logic             tooBig, runFound, pktFound;
  int               runBase, newPkt;

  logic [PKT_W-1:0] txqHead, doneHead, rxHead, relPkt;
  logic txqEmpty, txqFull, doneEmpty, doneFull, rxEmpty, rxFull;
  logic freeHit;

  function automatic logic [NUM_PAGES-1:0] spanMask(input int base, input int len);
    logic [NUM_PAGES-1:0] m;
    for (int i = 0; i < NUM_PAGES; i++) m[i] = (i >= base) && (i < base + len);
    return m;
  endfunction

  assign reqLen = LEN_W'(strobe.count[2:0]) + 1'b1;
  assign tooBig = |strobe.count[CNT_W-1:3];

  always_comb begin
    runFound = 1'b0;
    runBase  = 0;
    for (int b = NUM_PAGES - 1; b >= 0; b--) begin
      if ((b + int'(reqLen) <= NUM_PAGES) &&
          ((pageUsed & spanMask(b, int'(reqLen))) == '0)) begin
        runFound = 1'b1;
        runBase  = b;
      end
    end
    pktFound = 1'b0;
    newPkt   = 0;
    for (int p = NUM_PKTS - 1; p >= 0; p--) begin
      if (!pktUsed[p]) begin
        pktFound = 1'b1;
        newPkt   = p;
      end
    end
  end

  assign allocOk = !tooBig && runFound && pktFound;

  assign relPkt  = strobe.doRel ? rxHead : strobe.pkt[PKT_W-1:0];
  assign freeHit = ((strobe.doFree && (int'(strobe.pkt) < NUM_PKTS)) ||
                    (strobe.doRel && !rxEmpty)) && pktUsed[relPkt];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.doClear) begin
      pageUsed    <= '0;
      pktUsed     <= '0;
      allocResult <= 8'h80;
    end else if (strobe.doAlloc) begin
      if (allocOk) begin
        pageUsed        <= pageUsed | spanMask(runBase, int'(reqLen));
        pktUsed[newPkt] <= 1'b1;
        pktBase[newPkt] <= PG_W'(runBase);
        pktLen[newPkt]  <= reqLen;
        allocResult     <= {1'b0, PKT_FIELD_W'(newPkt)};
      end else begin
        allocResult <= 8'h80;
      end
    end else if (freeHit) begin
      pageUsed        <= pageUsed & ~spanMask(int'(pktBase[relPkt]), int'(pktLen[relPkt]));
      pktUsed[relPkt] <= 1'b0;
    end
  end

  assign txDoneAcc = txDone && !txqEmpty && !doneFull;

  mmu_fifo #(.W(PKT_W), .DEPTH(NUM_PKTS)) u_txq (
    .clk(clk), .rstN(rstN), .clear(strobe.doClear),
    .push(strobe.doEnq && (int'(strobe.pkt) < NUM_PKTS)),
    .pushData(strobe.pkt[PKT_W-1:0]),
    .pop(txDoneAcc), .head(txqHead), .empty(txqEmpty), .full(txqFull)
  );

  mmu_fifo #(.W(PKT_W), .DEPTH(NUM_PKTS)) u_doneq (
    .clk(clk), .rstN(rstN), .clear(strobe.doClear),
    .push(txDoneAcc), .pushData(txqHead),
    .pop(txDonePop), .head(doneHead), .empty(doneEmpty), .full(doneFull)
  );

  mmu_fifo #(.W(PKT_W), .DEPTH(NUM_PKTS)) u_rxq (
    .clk(clk), .rstN(rstN), .clear(strobe.doClear),
    .push(rxInjWr && (int'(rxInjPkt) < NUM_PKTS)),
    .pushData(rxInjPkt[PKT_W-1:0]),
    .pop(strobe.doRel), .head(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  assign txReqValid = !txqEmpty;
  assign txReqPkt   = PKT_FIELD_W'(txqHead);
  assign portStatus = {rxEmpty, PKT_FIELD_W'(rxHead), doneEmpty, PKT_FIELD_W'(doneHead)};

  logic unusedFull;
  assign unusedFull = txqFull ^ rxFull;
endmodule

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu
  import mmu_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int NUM_PKTS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic [7:0]  cmdData,
  input  logic [6:0]  selPkt,
  input  logic [1:0]  intAck,
  input  logic        txDone,
  input  logic        txDonePop,
  input  logic        rxInjWr,
  input  logic [6:0]  rxInjPkt,
  output logic [7:0]  allocResult,
  output logic [1:0]  intStatus,
  output logic [15:0] portStatus,
  output logic        txReqValid,
  output logic [6:0]  txReqPkt
);
  mmuStrobe_t strobe;
  logic       allocOk;
  logic       txDoneAcc;

  mmu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
    .selPkt(selPkt), .intAck(intAck), .allocOk(allocOk),
    .txDoneAcc(txDoneAcc), .strobe(strobe), .intStatus(intStatus)
  );

  mmu_dpath #(.NUM_PAGES(NUM_PAGES), .NUM_PKTS(NUM_PKTS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txDone(txDone),
    .txDonePop(txDonePop), .rxInjWr(rxInjWr), .rxInjPkt(rxInjPkt),
    .allocOk(allocOk), .txDoneAcc(txDoneAcc), .allocResult(allocResult),
    .portStatus(portStatus), .txReqValid(txReqValid), .txReqPkt(txReqPkt)
  );
endmodule

// File: rtl/mmu_chk.sv
module mmu_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdWr,
  input logic [7:0]  cmdData,
  input logic        txDone,
  input logic        txReqValid,
  input logic [7:0]  allocResult,
  input logic [1:0]  intStatus,
  input logic [15:0] portStatus
);
  logic chkPend;

  always_ff @(posedge clk) begin
    if (!rstN) chkPend <= 1'b0;
    else       chkPend <= cmdWr && !chkPend && (cmdData[7:5] == 3'd1);
  end

  // R4
  fail_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocResult[7] |-> (allocResult[6:0] == 7'd0));

  // R5
  alloc_int_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[0]) |-> ($past(chkPend) && !allocResult[7]));

  // R6
  result_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(allocResult) |-> ($past(chkPend) ||
      $past(cmdWr && !chkPend && (cmdData[7:5] == 3'd2))));

  // R8
  tx_int_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[1]) |-> $past(txDone && txReqValid));

  // R9
  done_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    portStatus[7] |-> (portStatus[6:0] == 7'd0));

  // R11
  rx_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    portStatus[15] |-> (portStatus[14:8] == 7'd0));
endmodule

bind pkt_page_mmu mmu_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
  .txDone(txDone), .txReqValid(txReqValid), .allocResult(allocResult),
  .intStatus(intStatus), .portStatus(portStatus)
);

// File: tb/sim_pkt_page_mmu.sv
`timescale 1ns/1ps
module sim_pkt_page_mmu;
  logic clk = 0, rstN = 0;
  logic cmdWr = 0, txDone = 0, txDonePop = 0, rxInjWr = 0;
  logic [7:0] cmdData = 0;
  logic [6:0] selPkt = 0, rxInjPkt = 0;
  logic [1:0] intAck = 0;
  logic [7:0] allocResult;
  logic [1:0] intStatus;
  logic [15:0] portStatus;
  logic txReqValid;
  logic [6:0] txReqPkt;

  int nChecks = 0, nFail = 0;
  bit [15:0] mPages;
  bit [7:0]  mUsed;
  int mBase [8];
  int mLen  [8];

  always #4 clk = ~clk;

  pkt_page_mmu u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  function automatic void modelClear();
    mPages = '0;
    mUsed  = '0;
  endfunction

  function automatic logic [7:0] modelAlloc(input int n);
    int fb = -1, fp = -1, len;
    if (n > 7) return 8'h80;
    len = n + 1;
    for (int b = 0; b <= 16 - len; b++) begin
      bit ok = 1;
      for (int k = 0; k < len; k++) if (mPages[b+k]) ok = 0;
      if (ok && fb < 0) fb = b;
    end
    for (int p = 0; p < 8; p++) if (!mUsed[p] && fp < 0) fp = p;
    if (fb < 0 || fp < 0) return 8'h80;
    for (int k = 0; k < len; k++) mPages[fb+k] = 1;
    mUsed[fp] = 1; mBase[fp] = fb; mLen[fp] = len;
    return 8'(fp);
  endfunction

  function automatic void modelFree(input int p);
    if (p < 8 && mUsed[p]) begin
      for (int k = 0; k < mLen[p]; k++) mPages[mBase[p]+k] = 0;
      mUsed[p] = 0;
    end
  endfunction

  task automatic writeCmd(input int op, input int n, input int sel);
    @(negedge clk);
    cmdWr = 1; cmdData = {3'(op), 5'(n)}; selPkt = 7'(sel);
    @(negedge clk);
    cmdWr = 0;
  endtask

  task automatic ackInt(input logic [1:0] m);
    @(negedge clk); intAck = m;
    @(negedge clk); intAck = 0;
  endtask

  task automatic allocCheck(input int n, input string req);
    logic [7:0] exp;
    writeCmd(1, n, 0);
    @(negedge clk);
    exp = modelAlloc(n);
    check(allocResult == exp, req, allocResult, exp);
    check(intStatus[0] == !exp[7], "R5", intStatus[0], !exp[7]);
    if (intStatus[0]) ackInt(2'b01);
  endtask

  task automatic clearAll();
    writeCmd(2, 0, 0);
    modelClear();
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(allocResult == 8'h80, "R1", allocResult, 8'h80);
    check(portStatus == 16'h8080, "R1", portStatus, 16'h8080);
    rstN = 1;
    @(negedge clk);
    check(intStatus == 0, "R1", intStatus, 0);
    check(txReqValid == 0, "R1", txReqValid, 0);
    modelClear();

    // R2 R4: sweep count field on an empty pool
    for (int n = 0; n < 32; n++) begin
      clearAll();
      allocCheck(n, n > 7 ? "R4" : "R2");
    end

    // R3 R4: fill pool, then free and refill
    clearAll();
    for (int i = 0; i < 10; i++) allocCheck(i % 3, "R3");
    for (int p = 1; p < 8; p += 2) begin writeCmd(4, 0, p); modelFree(p); end
    writeCmd(4, 0, 3); modelFree(3);          // R10 second free of same number
    writeCmd(4, 0, 9); modelFree(9);          // R10 out-of-range number
    for (int i = 0; i < 8; i++) allocCheck((i * 5) % 8, "R10");
    for (int p = 0; p < 8; p++) begin writeCmd(4, 0, p); modelFree(p); end
    for (int i = 0; i < 4; i++) allocCheck(3, "R3");
    allocCheck(0, "R4");

    // R5: set and clear in the same cycle, set wins
    clearAll();
    writeCmd(1, 0, 0);
    intAck = 2'b01;
    @(negedge clk); intAck = 0;
    void'(modelAlloc(0));
    check(intStatus[0] == 1, "R5", intStatus[0], 1);
    ackInt(2'b01);
    check(intStatus[0] == 0, "R5", intStatus[0], 0);

    // R6: clear-all written during the pending cycle is ignored
    clearAll();
    @(negedge clk); cmdWr = 1; cmdData = {3'd1, 5'd0};
    @(negedge clk); cmdData = {3'd2, 5'd0};
    @(negedge clk); cmdWr = 0;
    void'(modelAlloc(0));
    check(allocResult == 8'h00, "R6", allocResult, 0);
    ackInt(2'b01);
    allocCheck(0, "R6");

    // R8 R9: transmit and completion queues
    clearAll();
    for (int i = 0; i < 3; i++) allocCheck(0, "R8");
    writeCmd(3, 0, 2);
    writeCmd(3, 0, 0);
    check(txReqValid && txReqPkt == 2, "R8", txReqPkt, 2);
    pulse(txDone);
    check(portStatus[7:0] == 8'h02, "R9", portStatus[7:0], 2);
    check(intStatus[1] == 1, "R8", intStatus[1], 1);
    check(txReqPkt == 0, "R8", txReqPkt, 0);
    pulse(txDone);
    check(portStatus[7:0] == 8'h02, "R9", portStatus[7:0], 2);
    check(txReqValid == 0, "R8", txReqValid, 0);
    pulse(txDonePop);
    check(portStatus[7:0] == 8'h00, "R9", portStatus[7:0], 0);
    pulse(txDonePop);
    check(portStatus[7:0] == 8'h80, "R9", portStatus[7:0], 8'h80);
    ackInt(2'b10);
    check(intStatus[1] == 0, "R8", intStatus[1], 0);
    pulse(txDone);
    check(intStatus[1] == 0 && portStatus[7:0] == 8'h80, "R8", intStatus[1], 0);

    // R11: receive queue and release
    clearAll();
    allocCheck(7, "R11");
    allocCheck(7, "R11");
    @(negedge clk); rxInjWr = 1; rxInjPkt = 1;
    @(negedge clk); rxInjPkt = 0;
    @(negedge clk); rxInjWr = 0;
    check(portStatus[15:8] == 8'h01, "R11", portStatus[15:8], 1);
    writeCmd(5, 0, 0); modelFree(1);
    check(portStatus[15:8] == 8'h00, "R11", portStatus[15:8], 0);
    allocCheck(7, "R11");
    writeCmd(5, 0, 0); modelFree(0);
    check(portStatus[15:8] == 8'h80, "R11", portStatus[15:8], 8'h80);
    allocCheck(7, "R11");
    writeCmd(5, 0, 0);
    check(portStatus[15:8] == 8'h80, "R11", portStatus[15:8], 8'h80);
    allocCheck(0, "R11");

    // R7: clear-all with queues and interrupts active
    writeCmd(3, 0, 0);
    @(negedge clk); rxInjWr = 1; rxInjPkt = 1;
    @(negedge clk); rxInjWr = 0;
    pulse(txDone);
    writeCmd(3, 0, 1);
    check(txReqValid == 1 && intStatus[1] == 1, "R7", txReqValid, 1);
    clearAll();
    check(portStatus == 16'h8080, "R7", portStatus, 16'h8080);
    check(txReqValid == 0 && intStatus == 0, "R7", {txReqValid, intStatus}, 0);
    check(allocResult == 8'h80, "R7", allocResult, 8'h80);
    allocCheck(7, "R7");
    allocCheck(7, "R7");

    finishRun();
  end
endmodule